// File: doc/BRIEF.md
# Dual Bus-Master DMA Channel Controller

This block sequences two bus-master DMA channels that move 32-bit words between a host bus and a local bus through two small FIFOs. The inbound channel (channel index 0) fetches words from host memory into an inbound FIFO that the local side drains. The outbound channel (channel index 1) takes words that the local side has pushed into an outbound FIFO and writes them to host memory. Each channel has a start address, a word count, a run bit and a hold bit. A six-bit status word reports completion, errors and the FIFO levels the local side needs in order to pace itself.

Control writes are strobes, one per channel. A write with the run bit at 0 stops the channel and clears it. A write with the run bit at 1 to a stopped channel loads the address and count and starts it. A write with the run bit at 1 to a running channel only updates its hold bit.

The host bus is modelled as a request/grant handshake. The master presents an address, a direction and a burst size while it requests. After the grant, each acknowledge cycle moves one word. A master-abort or target-abort pulse ends the burst with an error.

Top module: `dual_dma_ctrl`

## Requirements
- R1: After reset, `bus_req` is 0 and `status` is 6'b000100. The status bits are [0] inbound complete, [1] outbound complete, [2] inbound FIFO empty, [3] outbound FIFO full, [4] inbound error and [5] outbound error.
- R2: A control write with run=0 followed by a write with run=1 loads `ctl_base` and `ctl_len`. The channel's first request carries `bus_addr` equal to the loaded base.
- R3: A run=1 write to a channel that is already running changes neither its address nor its remaining count. A new base or length presented with that write is ignored.
- R4: A run=0 write stops the channel, clears its complete and error bits and withdraws further requests. The next start begins from the newly written base.
- R5: While the hold bit is set, a channel raises no new request, but it keeps its address and count. A request already raised stays up until it is granted, and that burst runs to the end. Clearing the hold bit resumes the transfer at the next word address.
- R6: The outbound channel requests only when its FIFO holds min(4, remaining) words, so it uses full 4-word bursts except for the tail of the block.
- R7: The inbound complete bit (bit 0) sets once the last word of the block has been written into the inbound FIFO. Bits 0 and 2 both set means the whole block has been read out locally.
- R8: The outbound complete bit (bit 1) sets only after the last word has been acknowledged on the host bus.
- R9: A master-abort or target-abort during a burst sets that channel's error bit (bit 4 inbound, bit 5 outbound). The channel then requests nothing until it receives a run=0 write.
- R10: `bus_blen` is min(4, remaining). The inbound channel requests only when the FIFO has room for that many words. The address advances by 4 per acknowledged word.
- R11: When both channels request at once, the inbound channel is granted first.
- R12: Status bit 2 tracks the inbound FIFO being empty and bit 3 tracks the outbound FIFO holding 4 words. Status is registered one cycle behind the state it reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 2 | Per-channel control write strobe (bit 0 inbound, bit 1 outbound) |
| ctl_enable | input | 1 | Run bit value for the write |
| ctl_pause | input | 1 | Hold bit value for the write |
| ctl_base | input | AW | Start byte address, loaded on start |
| ctl_len | input | LW | Block length in words, loaded on start |
| lw_en | input | 1 | Local push into the outbound FIFO |
| lw_data | input | DW | Local push data |
| lr_en | input | 1 | Local pop from the inbound FIFO |
| lr_data | output | DW | Inbound FIFO head word |
| bus_req | output | 1 | Host bus request |
| bus_write | output | 1 | 1 = write to host (outbound), 0 = read |
| bus_addr | output | AW | Current word address |
| bus_blen | output | CW | Words in the requested burst |
| bus_wdata | output | DW | Outbound write data |
| bus_gnt | input | 1 | Grant for the pending request |
| bus_ack | input | 1 | One word transferred this cycle |
| bus_rdata | input | DW | Read data from the host |
| bus_mabort | input | 1 | Master abort, no target responded |
| bus_tabort | input | 1 | Target abort |
| status | output | 6 | Registered status word, see R1 |

## Verification
A control write is captured at the next clock edge, so a request appears two edges later: one edge to enter the wait state and one more to raise the request. A completion or error flag changes at the edge of the acknowledge or abort that causes it, and the status word shows the change one edge after that. The bench drives inputs and samples outputs on falling edges. It records each expected request in a queue, which the bus responder pops at the grant. Status is checked only after the expected request queue has drained and two further edges have passed. Quiet-period checks watch `bus_req` on each of ten consecutive cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_REQ,
    ST_BURST,
    ST_DONE,
    ST_ERR
  } dma_st_e;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DW = 32,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic push, pop;

  assign push = wr_en && (count != CW'(DEPTH));
  assign pop  = rd_en && (count != '0);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + PW'(1);
      if (pop)  rptr <= rptr + PW'(1);
      if (push && !pop) count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R12
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DEPTH = 4,
  parameter bit IS_OUT = 1'b0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          ctl_enable,
  input  logic          ctl_pause,
  input  logic [AW-1:0] ctl_base,
  input  logic [LW-1:0] ctl_len,
  input  logic [CW-1:0] fifo_lvl,
  input  logic          gnt,
  input  logic          ack,
  input  logic          abort,
  output logic          req,
  output logic          burst,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] blen,
  output logic          done,
  output logic          err
);
  dma_st_e       st;
  logic          enable_q, pause_q;
  logic [LW-1:0] remain;
  logic [CW-1:0] left;
  logic [CW-1:0] bsz;
  logic          ready;
  logic          stop_wr;

  assign stop_wr = ctl_wr && !ctl_enable;
  assign bsz = (remain < LW'(DEPTH)) ? CW'(remain) : CW'(DEPTH);

  generate
    if (IS_OUT) begin : g_out
      assign ready = fifo_lvl >= bsz;
    end else begin : g_in
      assign ready = (CW'(DEPTH) - fifo_lvl) >= bsz;
    end
  endgenerate

  assign req   = (st == ST_REQ);
  assign burst = (st == ST_BURST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      enable_q <= 1'b0;
      pause_q  <= 1'b0;
      addr     <= '0;
      remain   <= '0;
      left     <= '0;
      blen     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else if (stop_wr) begin
      st       <= ST_IDLE;
      enable_q <= 1'b0;
      pause_q  <= ctl_pause;
      addr     <= '0;
      remain   <= '0;
      left     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (ctl_wr) pause_q <= ctl_pause;
      if (ctl_wr && !enable_q) begin
        enable_q <= 1'b1;
        addr     <= ctl_base;
        remain   <= ctl_len;
        done     <= (ctl_len == '0);
        st       <= (ctl_len == '0) ? ST_DONE : ST_RUN;
      end else begin
        case (st)
          ST_RUN: begin
            if (!pause_q && ready && remain != '0) begin
              st   <= ST_REQ;
              blen <= bsz;
              left <= bsz;
            end
          end
          ST_REQ: begin
            if (abort) begin
              st  <= ST_ERR;
              err <= 1'b1;
            end else if (gnt) begin
              st <= ST_BURST;
            end
          end
          ST_BURST: begin
            if (abort) begin
              st  <= ST_ERR;
              err <= 1'b1;
            end else if (ack) begin
              addr   <= addr + AW'(4);
              remain <= remain - LW'(1);
              left   <= left - CW'(1);
              if (left == CW'(1)) begin
                if (remain == LW'(1)) begin
                  st   <= ST_DONE;
                  done <= 1'b1;
                end else begin
                  st <= ST_RUN;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req && !gnt && !abort && !stop_wr |=> req); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> !req && !burst); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    burst && ack && !abort && !stop_wr |=> addr == $past(addr) + AW'(4)); // R10

  generate
    if (IS_OUT) begin : g_out_chk
      AST_OUT_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> fifo_lvl >= blen); // R6
    end
  endgenerate
endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ctl_wr,
  input  logic          ctl_enable,
  input  logic          ctl_pause,
  input  logic [AW-1:0] ctl_base,
  input  logic [LW-1:0] ctl_len,
  input  logic          lw_en,
  input  logic [DW-1:0] lw_data,
  input  logic          lr_en,
  output logic [DW-1:0] lr_data,
  output logic          bus_req,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [CW-1:0] bus_blen,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_mabort,
  input  logic          bus_tabort,
  output logic [5:0]    status
);
  logic [1:0]    req_c, burst_c, done_c, err_c, gnt_c, ack_c, abt_c;
  logic [AW-1:0] addr_c [2];
  logic [CW-1:0] blen_c [2];
  logic [CW-1:0] lvl_c  [2];
  logic          sel_out;
  logic          abort;

  assign abort   = bus_mabort || bus_tabort;
  assign sel_out = burst_c[1] || (!burst_c[0] && !req_c[0]);

  assign bus_req   = sel_out ? req_c[1] : req_c[0];
  assign bus_write = sel_out;
  assign bus_addr  = sel_out ? addr_c[1] : addr_c[0];
  assign bus_blen  = sel_out ? blen_c[1] : blen_c[0];

  assign gnt_c = {bus_gnt && sel_out, bus_gnt && !sel_out};
  assign ack_c = {bus_ack && sel_out, bus_ack && !sel_out};
  assign abt_c = {abort && sel_out, abort && !sel_out};

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst(rst),
    .wr_en(bus_ack && burst_c[0]), .wr_data(bus_rdata),
    .rd_en(lr_en), .rd_data(lr_data), .count(lvl_c[0])
  );

  dma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst(rst),
    .wr_en(lw_en), .wr_data(lw_data),
    .rd_en(bus_ack && burst_c[1]), .rd_data(bus_wdata), .count(lvl_c[1])
  );

  generate
    for (genvar c = 0; c < 2; c++) begin : g_chan
      dma_chan #(.AW(AW), .LW(LW), .DEPTH(DEPTH), .IS_OUT(c == 1)) u_chan (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr[c]), .ctl_enable(ctl_enable), .ctl_pause(ctl_pause),
        .ctl_base(ctl_base), .ctl_len(ctl_len),
        .fifo_lvl(lvl_c[c]),
        .gnt(gnt_c[c]), .ack(ack_c[c]), .abort(abt_c[c]),
        .req(req_c[c]), .burst(burst_c[c]),
        .addr(addr_c[c]), .blen(blen_c[c]),
        .done(done_c[c]), .err(err_c[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) status <= 6'b000100;
    else status <= {err_c[1], err_c[0], (lvl_c[1] == CW'(DEPTH)),
                    (lvl_c[0] == '0), done_c[1], done_c[0]};
  end

  AST_IN_ROOM: assert property (@(posedge clk) disable iff (rst)
    bus_ack && burst_c[0] |-> lvl_c[0] != CW'(DEPTH)); // R10
  AST_PRIO: assert property (@(posedge clk) disable iff (rst)
    bus_gnt && !abort && req_c[0] && !burst_c[1] |=> burst_c[0]); // R11
  AST_ONE_BURST: assert property (@(posedge clk) disable iff (rst)
    !(burst_c[0] && burst_c[1])); // R11
endmodule

// File: tb/dual_dma_ctrl_bench.sv
module dual_dma_ctrl_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  ctl_wr = 0;
  logic        ctl_enable = 0, ctl_pause = 0;
  logic [31:0] ctl_base = 0;
  logic [15:0] ctl_len = 0;
  logic        lw_en = 0, lr_en = 0;
  logic [31:0] lw_data = 0;
  logic [31:0] lr_data;
  logic        bus_req, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [2:0]  bus_blen;
  logic        bus_gnt, bus_ack, bus_mabort, bus_tabort;
  logic [31:0] bus_rdata;
  logic [5:0]  status;

  always #5 clk = ~clk;

  dual_dma_ctrl u_dual_dma_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
    .ctl_pause(ctl_pause), .ctl_base(ctl_base), .ctl_len(ctl_len),
    .lw_en(lw_en), .lw_data(lw_data), .lr_en(lr_en), .lr_data(lr_data),
    .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_blen(bus_blen), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_mabort(bus_mabort),
    .bus_tabort(bus_tabort), .status(status)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [40:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] in_q [$];
  logic [31:0] out_q [$];
  int  rs = 0, cnt = 0, wc = 0, abort_mode = 0;
  bit  hold = 0, wr_burst = 0;
  logic [31:0] ov = 32'h0B00_0000;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_word();
    bus_ack = 1;
    cnt--;
    if (wr_burst) begin
      logic [31:0] e;
      e = (out_q.size() > 0) ? out_q.pop_front() : 32'hx;
      chk(bus_wdata === e, "R8 write data", bus_wdata, e);
    end else begin
      bus_rdata = 32'hD000_0000 + wc;
      in_q.push_back(bus_rdata);
      wc++;
    end
  endtask

  // bus responder and request monitor
  initial begin
    bus_gnt = 0; bus_ack = 0; bus_mabort = 0; bus_tabort = 0; bus_rdata = 0;
    forever begin
      @(negedge clk);
      case (rs)
        0: begin
          bus_ack = 0; bus_mabort = 0; bus_tabort = 0;
          if (!rst && bus_req && !hold) begin
            logic [40:0] got;
            got = {bus_write, bus_addr, 5'd0, bus_blen};
            if (exp_q.size() == 0) begin
              chk(0, "unexpected request", got, 0);
            end else begin
              logic [40:0] e;
              string t;
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              chk(got == e, t, got, e);
            end
            cnt = int'(bus_blen);
            wr_burst = bus_write;
            bus_gnt = 1;
            rs = 1;
          end
        end
        1: begin
          bus_gnt = 0;
          if (abort_mode == 1) begin bus_mabort = 1; rs = 3; end
          else if (abort_mode == 2) begin bus_tabort = 1; rs = 3; end
          else begin do_word(); rs = 2; end
        end
        2: begin
          if (cnt == 0) begin bus_ack = 0; rs = 0; end
          else do_word();
        end
        default: begin bus_mabort = 0; bus_tabort = 0; rs = 0; end
      endcase
    end
  end

  task automatic exp_req(input bit w, input logic [31:0] a, input int n, input string t);
    exp_q.push_back({w, a, 8'(n)});
    tag_q.push_back(t);
  endtask

  task automatic cwrite(input int ch, input bit en, input bit pa, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    ctl_wr = 2'b01 << ch; ctl_enable = en; ctl_pause = pa; ctl_base = b; ctl_len = l;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic lread(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] e;
      @(negedge clk);
      e = (in_q.size() > 0) ? in_q.pop_front() : 32'hx;
      chk(lr_data === e, "R7 inbound data", lr_data, e);
      lr_en = 1;
    end
    @(negedge clk);
    lr_en = 0;
  endtask

  task automatic lwrite(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lw_en = 1; lw_data = ov; out_q.push_back(ov); ov++;
    end
    @(negedge clk);
    lw_en = 0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || rs != 0) && t < 2000) begin
      @(negedge clk); t++;
    end
    chk(t < 2000, "expected request timeout", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_req();
    int t;
    t = 0;
    while (!bus_req && t < 200) begin @(negedge clk); t++; end
    chk(bus_req, "R5 request raised", bus_req, 1);
  endtask

  task automatic no_req(input int n, input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_req) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic chk_stat(input logic [5:0] mask, input logic [5:0] e, input string tag);
    @(negedge clk);
    chk((status & mask) == e, tag, status & mask, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(status == 6'b000100, "R1 reset status", status, 6'b000100);
    chk(!bus_req, "R1 reset request", bus_req, 0);

    // R2 start, R10 room and burst size, R7 completion
    cwrite(0, 0, 0, 0, 0);
    exp_req(0, 32'h100, 4, "R2 first request");
    cwrite(0, 1, 0, 32'h100, 6);
    wait_idle();
    no_req(10, "R10 no request without FIFO room");
    chk_stat(6'b000100, 6'b000000, "R12 inbound not empty");
    exp_req(0, 32'h110, 2, "R10 tail burst");
    lread(4);
    wait_idle();
    chk_stat(6'b000101, 6'b000001, "R7 complete but not empty");
    lread(2);
    repeat (2) @(negedge clk);
    chk_stat(6'b000101, 6'b000101, "R7 block fully read");
    cwrite(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk_stat(6'b000001, 6'b000000, "R4 complete cleared");

    // R3 run=1 while running
    exp_req(0, 32'h200, 4, "R2 restart at new base");
    cwrite(0, 1, 0, 32'h200, 8);
    wait_idle();
    cwrite(0, 1, 0, 32'h900, 2);
    no_req(10, "R3 rewrite no effect");
    exp_req(0, 32'h210, 4, "R3 continues at old pointer");
    lread(4);
    wait_idle();
    lread(4);
    chk_stat(6'b000001, 6'b000001, "R3 full original length done");
    cwrite(0, 0, 0, 0, 0);
    no_req(10, "R4 stopped channel quiet");

    // R5 hold
    cwrite(0, 1, 1, 32'h300, 8);
    no_req(10, "R5 no request while held");
    hold = 1;
    exp_req(0, 32'h300, 4, "R5 burst after release");
    cwrite(0, 1, 0, 0, 0);
    wait_req();
    cwrite(0, 1, 1, 0, 0);
    chk(bus_req, "R5 raised request kept", bus_req, 1);
    hold = 0;
    wait_idle();
    lread(4);
    no_req(10, "R5 held between bursts");
    exp_req(0, 32'h310, 4, "R5 resume at next word");
    cwrite(0, 1, 0, 0, 0);
    wait_idle();
    lread(4);
    cwrite(0, 0, 0, 0, 0);

    // R6 outbound threshold, R12 full flag, R8 completion
    cwrite(1, 0, 0, 0, 0);
    cwrite(1, 1, 0, 32'h400, 6);
    lwrite(3);
    no_req(10, "R6 no burst below 4 words");
    cwrite(1, 1, 1, 0, 0);
    lwrite(1);
    repeat (2) @(negedge clk);
    chk_stat(6'b001000, 6'b001000, "R12 outbound full");
    no_req(10, "R5 outbound held");
    exp_req(1, 32'h400, 4, "R6 full burst");
    cwrite(1, 1, 0, 0, 0);
    wait_idle();
    chk_stat(6'b001010, 6'b000000, "R8 not complete yet");
    lwrite(1);
    no_req(10, "R6 tail waits for 2 words");
    exp_req(1, 32'h410, 2, "R6 tail burst");
    lwrite(1);
    wait_idle();
    chk_stat(6'b000010, 6'b000010, "R8 outbound complete");
    cwrite(1, 0, 0, 0, 0);

    // R11 priority
    hold = 1;
    cwrite(1, 1, 0, 32'h500, 4);
    lwrite(4);
    wait_req();
    cwrite(0, 1, 0, 32'h700, 4);
    repeat (3) @(negedge clk);
    exp_req(0, 32'h700, 4, "R11 inbound first");
    exp_req(1, 32'h500, 4, "R11 outbound second");
    hold = 0;
    wait_idle();
    lread(4);
    chk_stat(6'b000011, 6'b000011, "R11 both complete");
    cwrite(0, 0, 0, 0, 0);
    cwrite(1, 0, 0, 0, 0);

    // R9 abort
    abort_mode = 1;
    exp_req(0, 32'h600, 4, "R9 aborted request");
    cwrite(0, 1, 0, 32'h600, 4);
    wait_idle();
    abort_mode = 0;
    chk_stat(6'b010001, 6'b010000, "R9 inbound error");
    no_req(10, "R9 quiet after abort");
    cwrite(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk_stat(6'b010000, 6'b000000, "R4 error cleared");
    exp_req(0, 32'h640, 4, "R4 restart after error");
    cwrite(0, 1, 0, 32'h640, 4);
    wait_idle();
    lread(4);
    cwrite(0, 0, 0, 0, 0);
    lwrite(4);
    abort_mode = 2;
    exp_req(1, 32'h800, 4, "R9 outbound aborted request");
    cwrite(1, 1, 0, 32'h800, 4);
    wait_idle();
    abort_mode = 0;
    chk_stat(6'b100010, 6'b100000, "R9 outbound error");
    out_q.delete();

    chk(exp_q.size() == 0 && in_q.size() == 0, "leftover expectations",
        exp_q.size() + in_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule